// File: doc/BRIEF.md
# Configurable CRC Accelerator

This block is a register-mapped CRC engine. Software programs a control word, loads a starting value into the seed register and issues a load command. It then writes data words one after another and reads the running result from the result register. Each accepted data write folds one 8-, 16- or 32-bit unit into the CRC within a single clock. The next cycle the result is readable.

The control word selects one of four polynomials (CCITT 16-bit, 8-bit, 16-bit and 32-bit) and the write length. It also selects four optional transforms. Two act on the incoming data: bit reversal within each byte, and one's complement. Two act on the result as it is read: reversal over the active CRC width, and one's complement over that width. The engine is non-reflected and shifts MSB first. The bus is a plain single-cycle interface: an address, a write strobe, write data, and combinational read data.

Top module: `crc_accel`

## Requirements
- R1: After a synchronous reset, all four registers (control at 0x00, data at 0x04, seed at 0x08, result at 0x0C) read zero.
- R2: Writing control with bit 1 set loads the seed register, masked to the newly selected CRC width, into the running CRC. Bit 1 is never stored and always reads back 0.
- R3: Control bits [31:30] choose the polynomial and width: 00 gives 0x1021 over 16 bits, 01 gives 0x07 over 8 bits, 10 gives 0x8005 over 16 bits, and 11 gives 0x04C11DB7 over 32 bits. The CRC is non-reflected and processes data MSB first.
- R4: Control bits [29:28] set the write length: 00 is 8 bits, 01 is 16 bits, and 1x is 32 bits. Bytes are consumed starting with the least significant byte, and data bits above the chosen length have no effect.
- R5: When control bit 24 is 1, the bits of each data byte are mirrored in place before the byte enters the CRC.
- R6: When control bit 26 is 1, the data is one's complemented before it enters the CRC.
- R7: On readout, control bit 25 mirrors the result over the active width, and control bit 27 complements it over the active width. Mirroring is applied first.
- R8: Result bits above the active CRC width read as zero.
- R9: While control bit 0 is 0, data writes leave the running CRC unchanged.
- R10: An enabled data write updates the running CRC at the next clock edge. The CRC does not change in cycles without a write.
- R11: Writes to the result offset 0x0C change nothing. Control reads back bits 0 and [31:24] as written, with the other bits zero. The data and seed registers read back their last written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset; bits [3:2] select the register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The assertions take the bus to be synchronous and free of X while reset is low. They also assume at most one register is written per cycle, so a seed load and a data update never arrive on the same edge. The bench drives every input on the falling edge, issues exactly one write per call and parks the strobe low between writes, which keeps the stimulus within those assumptions. It sweeps every polynomial, length, input transform and output transform over several data words. Fixed check values for the nine-byte ASCII string "123456789" anchor the arithmetic model.

// File: rtl/crc_accel_pkg.sv
package crc_accel_pkg;

    localparam int REG_W  = 32;
    localparam int BYTE_W = 8;
    localparam int NBYTES = REG_W / BYTE_W;
    localparam int CNT_W  = $clog2(NBYTES + 1);

    typedef enum logic [1:0] {
        POLY_CCITT = 2'b00,
        POLY_CRC8  = 2'b01,
        POLY_CRC16 = 2'b10,
        POLY_CRC32 = 2'b11
    } poly_sel_e;

    typedef enum logic [1:0] {
        OFS_CTRL = 2'b00,
        OFS_DATA = 2'b01,
        OFS_SEED = 2'b10,
        OFS_SUM  = 2'b11
    } reg_sel_e;

    // upper byte of the control word, MSB first
    typedef struct packed {
        poly_sel_e  poly;
        logic [1:0] len;
        logic       sum_inv;
        logic       din_inv;
        logic       sum_rev;
        logic       din_rev;
    } ctrl_cfg_t;

    typedef struct packed {
        logic [REG_W-1:0] bytes;
        logic [CNT_W-1:0] count;
    } din_unit_t;

    function automatic logic [REG_W-1:0] poly_value(input poly_sel_e sel);
        case (sel)
            POLY_CCITT: return 32'h0000_1021;
            POLY_CRC8:  return 32'h0000_0007;
            POLY_CRC16: return 32'h0000_8005;
            default:    return 32'h04C1_1DB7;
        endcase
    endfunction

    function automatic int poly_width(input poly_sel_e sel);
        case (sel)
            POLY_CRC8:  return 8;
            POLY_CRC32: return 32;
            default:    return 16;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] width_mask(input poly_sel_e sel);
        case (sel)
            POLY_CRC8:  return 32'h0000_00FF;
            POLY_CRC32: return 32'hFFFF_FFFF;
            default:    return 32'h0000_FFFF;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] len_bytes(input logic [1:0] len);
        case (len)
            2'b00:   return CNT_W'(1);
            2'b01:   return CNT_W'(2);
            default: return CNT_W'(NBYTES);
        endcase
    endfunction

    // one byte, MSB first, per-bit feedback from the top of the active width
    function automatic logic [REG_W-1:0] crc_feed_byte(input logic [REG_W-1:0] crc,
                                                       input logic [BYTE_W-1:0] b,
                                                       input poly_sel_e sel);
        logic [REG_W-1:0] c;
        logic [REG_W-1:0] m;
        logic [REG_W-1:0] p;
        int               top;
        logic             fb;
        c   = crc;
        m   = width_mask(sel);
        p   = poly_value(sel);
        top = poly_width(sel) - 1;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = c[top] ^ b[i];
            c  = (c << 1) & m;
            if (fb) c = c ^ p;
        end
        return c;
    endfunction

endpackage

// File: rtl/crc_din_shaper.sv
module crc_din_shaper
    import crc_accel_pkg::*;
(
    input  logic [REG_W-1:0] raw,
    input  ctrl_cfg_t        cfg,
    output din_unit_t        unit
);
    logic [REG_W-1:0] mirrored;

    genvar g, h;
    generate
        for (g = 0; g < NBYTES; g++) begin : g_byte
            for (h = 0; h < BYTE_W; h++) begin : g_bit
                assign mirrored[g*BYTE_W + h] = raw[g*BYTE_W + (BYTE_W - 1 - h)];
            end
        end
    endgenerate

    always_comb begin
        unit.bytes = cfg.din_rev ? mirrored : raw;
        if (cfg.din_inv) unit.bytes = ~unit.bytes;
        unit.count = len_bytes(cfg.len);
    end
endmodule

// File: rtl/crc_unit_update.sv
module crc_unit_update
    import crc_accel_pkg::*;
(
    input  logic [REG_W-1:0] crc_in,
    input  din_unit_t        unit,
    input  poly_sel_e        sel,
    output logic [REG_W-1:0] crc_out
);
    logic [REG_W-1:0] chain [NBYTES+1];

    assign chain[0] = crc_in;

    genvar k;
    generate
        for (k = 0; k < NBYTES; k++) begin : g_stage
            logic [REG_W-1:0] stepped;
            assign stepped      = crc_feed_byte(chain[k], unit.bytes[k*BYTE_W +: BYTE_W], sel);
            assign chain[k + 1] = (CNT_W'(k) < unit.count) ? stepped : chain[k];
        end
    endgenerate

    assign crc_out = chain[NBYTES];
endmodule

// File: rtl/crc_sum_shaper.sv
module crc_sum_shaper
    import crc_accel_pkg::*;
(
    input  logic [REG_W-1:0] crc,
    input  ctrl_cfg_t        cfg,
    output logic [REG_W-1:0] sum
);
    logic [REG_W-1:0] full_rev;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] aligned;
    logic [REG_W-1:0] mirrored;

    genvar g;
    generate
        for (g = 0; g < REG_W; g++) begin : g_rev
            assign full_rev[g] = crc[REG_W - 1 - g];
        end
    endgenerate

    always_comb begin
        mask     = width_mask(cfg.poly);
        aligned  = crc & mask;
        mirrored = full_rev >> (REG_W - poly_width(cfg.poly));
        sum      = cfg.sum_rev ? mirrored : aligned;
        if (cfg.sum_inv) sum = sum ^ mask;
    end
endmodule

// File: rtl/crc_accel.sv
module crc_accel
    import crc_accel_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata
);
    localparam int CFG_LSB = REG_W - $bits(ctrl_cfg_t);

    reg_sel_e         sel;
    ctrl_cfg_t        cfg_q;
    ctrl_cfg_t        new_cfg;
    logic             en_q;
    logic [REG_W-1:0] data_q;
    logic [REG_W-1:0] seed_q;
    logic [REG_W-1:0] crc_q;
    logic [REG_W-1:0] crc_next;
    logic [REG_W-1:0] sum_out;
    din_unit_t        unit;
    logic             ctrl_wr;
    logic             data_wr;
    logic             seed_wr;

    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign new_cfg = ctrl_cfg_t'(bus_wdata[REG_W-1:CFG_LSB]);
    assign ctrl_wr = bus_we && (sel == OFS_CTRL);
    assign data_wr = bus_we && (sel == OFS_DATA);
    assign seed_wr = bus_we && (sel == OFS_SEED);

    crc_din_shaper i_din (
        .raw  (bus_wdata),
        .cfg  (cfg_q),
        .unit (unit)
    );

    crc_unit_update i_upd (
        .crc_in  (crc_q),
        .unit    (unit),
        .sel     (cfg_q.poly),
        .crc_out (crc_next)
    );

    crc_sum_shaper i_sum (
        .crc (crc_q),
        .cfg (cfg_q),
        .sum (sum_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            cfg_q  <= '0;
            data_q <= '0;
            seed_q <= '0;
            crc_q  <= '0;
        end else begin
            if (ctrl_wr) begin
                en_q  <= bus_wdata[0];
                cfg_q <= new_cfg;
                if (bus_wdata[1]) crc_q <= seed_q & width_mask(new_cfg.poly);
            end
            if (data_wr) begin
                data_q <= bus_wdata;
                if (en_q) crc_q <= crc_next;
            end
            if (seed_wr) seed_q <= bus_wdata;
        end
    end

    always_comb begin
        case (sel)
            OFS_CTRL: bus_rdata = {cfg_q, {(CFG_LSB - 1){1'b0}}, en_q};
            OFS_DATA: bus_rdata = data_q;
            OFS_SEED: bus_rdata = seed_q;
            default:  bus_rdata = sum_out;
        endcase
    end

    AST_INIT_LOADS_SEED: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata[1]) |=> (crc_q == ($past(seed_q) & width_mask($past(new_cfg.poly))))); // R2
    AST_DISABLED_DATA_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !en_q) |=> $stable(crc_q)); // R9
    AST_IDLE_HOLDS_CRC: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> $stable(crc_q)); // R10
    AST_SUM_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == OFS_SUM) |=> ($stable(crc_q) && $stable(seed_q) && $stable(cfg_q))); // R11
    AST_CTRL_CMD_NOT_KEPT: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (sel != OFS_CTRL || !bus_rdata[1])); // R2
endmodule

// File: tb/test_crc_accel.sv
module test_crc_accel;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    crc_accel i_crc_accel (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int m_width(input logic [1:0] mode);
        return (mode == 2'b01) ? 8 : (mode == 2'b11) ? 32 : 16;
    endfunction

    function automatic logic [31:0] m_mask(input logic [1:0] mode);
        return (m_width(mode) == 32) ? 32'hFFFF_FFFF : ((32'h1 << m_width(mode)) - 32'h1);
    endfunction

    function automatic logic [31:0] m_poly(input logic [1:0] mode);
        case (mode)
            2'b00:   return 32'h1021;
            2'b01:   return 32'h07;
            2'b10:   return 32'h8005;
            default: return 32'h04C11DB7;
        endcase
    endfunction

    // byte-at-once formulation: xor the byte into the top, then shift 8 times
    function automatic logic [31:0] m_word(input logic [31:0] crc, input logic [31:0] d,
                                           input logic [31:0] ctl);
        logic [31:0] c;
        logic [31:0] x;
        logic [31:0] mk;
        int w;
        int nb;
        w  = m_width(ctl[31:30]);
        mk = m_mask(ctl[31:30]);
        nb = (ctl[29:28] == 2'b00) ? 1 : (ctl[29:28] == 2'b01) ? 2 : 4;
        x  = d;
        if (ctl[24]) begin
            for (int i = 0; i < 32; i++) x[i] = d[(i / 8) * 8 + 7 - (i % 8)];
        end
        if (ctl[26]) x = ~x;
        c = crc & mk;
        for (int k = 0; k < nb; k++) begin
            c = c ^ ({24'h0, x[k*8 +: 8]} << (w - 8));
            for (int j = 0; j < 8; j++) begin
                if (c[w-1]) c = ((c << 1) ^ m_poly(ctl[31:30])) & mk;
                else        c = (c << 1) & mk;
            end
        end
        return c;
    endfunction

    function automatic logic [31:0] m_out(input logic [31:0] crc, input logic [31:0] ctl);
        logic [31:0] v;
        logic [31:0] r;
        int w;
        w = m_width(ctl[31:30]);
        v = crc & m_mask(ctl[31:30]);
        if (ctl[25]) begin
            r = '0;
            for (int i = 0; i < w; i++) r[i] = v[w - 1 - i];
            v = r;
        end
        if (ctl[27]) v = v ^ m_mask(ctl[31:30]);
        return v;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctl(input logic [1:0] mode, input logic [1:0] len,
                                           input logic ocomp, input logic dcomp,
                                           input logic orev, input logic drev,
                                           input logic init, input logic en);
        return {mode, len, ocomp, dcomp, orev, drev, 22'h0, init, en};
    endfunction

    task automatic known(input logic [1:0] mode, input logic [31:0] seed, input logic [31:0] exp);
        logic [31:0] v;
        string s;
        s = "123456789";
        wr(4'h8, seed);
        wr(4'h0, mk_ctl(mode, 2'b00, 0, 0, 0, 0, 1, 1));
        for (int i = 0; i < 9; i++) wr(4'h4, {24'h0, s[i]});
        rd(4'hC, v);
        check("R3 R10 known vector", v, exp);
    endtask

    initial begin : watchdog
        int n;
        n = 0;
        while (!done && n < WATCHDOG) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected below %0d cycles", n, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        logic [31:0] ref_crc;
        logic [31:0] ctl;
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(4'(a * 4), v);
            check("R1 reset value", v, 32'h0);
        end

        // R3 anchors
        known(2'b11, 32'hFFFF_FFFF, 32'h0376_E6E7);
        known(2'b00, 32'h0000_FFFF, 32'h0000_29B1);
        known(2'b01, 32'h0000_0000, 32'h0000_00F4);
        known(2'b10, 32'h0000_0000, 32'h0000_FEE8);

        // R2 seed load masked to width, command bit not kept
        wr(4'h8, 32'h1234_5678);
        wr(4'h0, mk_ctl(2'b01, 2'b00, 0, 0, 0, 0, 1, 1));
        rd(4'hC, v);
        check("R2 seed load", v, 32'h78);
        rd(4'h0, v);
        check("R2 command bit reads zero", v[1], 32'h0);
        check("R11 control readback", v, mk_ctl(2'b01, 2'b00, 0, 0, 0, 0, 0, 1));
        // R8 upper bits zero after switching to 32-bit mode then back to 8
        wr(4'h0, mk_ctl(2'b11, 2'b00, 0, 0, 0, 0, 1, 1));
        wr(4'h0, mk_ctl(2'b01, 2'b00, 0, 0, 0, 0, 0, 1));
        rd(4'hC, v);
        check("R8 upper result bits", v, 32'h78);

        // R11 result offset write ignored, seed/data readback
        wr(4'hC, 32'hDEAD_BEEF);
        rd(4'hC, v);
        check("R11 result write ignored", v, 32'h78);
        rd(4'h8, v);
        check("R11 seed readback", v, 32'h1234_5678);
        wr(4'h4, 32'hCAFE_F00D);
        rd(4'h4, v);
        check("R11 data readback", v, 32'hCAFE_F00D);

        // R9 disabled writes ignored
        wr(4'h0, mk_ctl(2'b11, 2'b10, 0, 0, 0, 0, 1, 0));
        wr(4'h4, 32'h0BAD_0BAD);
        rd(4'hC, v);
        check("R9 disabled data ignored", v, 32'h1234_5678);

        // R3-R7 sweep
        for (int mode = 0; mode < 4; mode++) begin
            for (int len = 0; len < 4; len++) begin
                for (int din = 0; din < 4; din++) begin
                    wr(4'h8, 32'h5A5A_0000 ^ 32'(mode * 977 + len * 131 + din * 17));
                    ctl = mk_ctl(2'(mode), 2'(len), 0, din[1], 0, din[0], 1, 1);
                    wr(4'h0, ctl);
                    ref_crc = (32'h5A5A_0000 ^ 32'(mode * 977 + len * 131 + din * 17)) & m_mask(2'(mode));
                    for (int w = 0; w < 3; w++) begin
                        d = 32'hA5C3_1E7B ^ (32'(w + 4 * din + 16 * len) * 32'h9E37_79B9);
                        wr(4'h4, d);
                        ref_crc = m_word(ref_crc, d, ctl);
                    end
                    for (int o = 0; o < 4; o++) begin
                        ctl = mk_ctl(2'(mode), 2'(len), o[1], din[1], o[0], din[0], 0, 1);
                        wr(4'h0, ctl);
                        rd(4'hC, v);
                        check("R3 R4 R5 R6 R7 sweep", v, m_out(ref_crc, ctl));
                    end
                end
            end
        end

        // R4 bits above the length ignored
        wr(4'h8, 32'h0);
        wr(4'h0, mk_ctl(2'b11, 2'b01, 0, 0, 0, 0, 1, 1));
        wr(4'h4, 32'hFFFF_1234);
        rd(4'hC, v);
        check("R4 upper data ignored", v, m_word(32'h0, 32'h0000_1234, mk_ctl(2'b11, 2'b01, 0, 0, 0, 0, 0, 1)));

        // R10 idle cycles hold
        repeat (5) @(negedge clk);
        rd(4'hC, ref_crc);
        check("R10 idle hold", ref_crc, v);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule